// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Buffer

This block is a direct-mapped first-level data cache controller that keeps the next memory level up to date on every store. It sits between a processor request port and a next-level memory port. Both ports use a valid/ready handshake. Loads that hit return their word one cycle after acceptance. A store is copied into the cache only when its line is resident. Every store is also posted into a small first-in first-out buffer. That buffer drains toward memory on its own, so the processor never waits for memory latency on a store unless the buffer is full.

A load miss stalls the processor. The controller first empties the store buffer. It then requests the whole aligned block from memory, receives it one word per beat, writes the line and marks it valid. The held request then hits and completes. Lines are never dirty, so the old line is overwritten without any memory write. The processor must hold its request stable while ready is low. Addresses are word addresses: bits [1:0] select the word in a four-word line, bits [5:2] select one of 16 lines, and the bits above form the tag.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid and the store buffer is empty: no memory request is issued, and the first load to any address misses.
- R2: A load that hits is accepted in the cycle it is presented (ready high), produces no memory traffic, and returns the cached word with `cpu_rsp_valid` one cycle later.
- R3: The store buffer holds 4 entries. While it is full, a store is held (`cpu_req_ready` low) until an entry drains; a store with space is accepted at once.
- R4: A store that hits updates the cached word and posts the same word to the buffer. It is accepted in the cycle it is presented, with `cpu_rsp_valid` one cycle later, the same as a load hit.
- R5: A store that misses is only posted toward memory. It allocates no line and leaves the resident line at that index readable as a hit with its old data.
- R6: A load miss stalls the processor and issues one memory read with the block-aligned address (offset bits zero). It accepts 4 response beats for words 0 to 3, fills the line, then returns the requested word. The replaced line causes no memory write.
- R7: No memory read is issued while the store buffer holds any entry, so a fetched block includes every earlier store.
- R8: Buffered stores reach memory in acceptance order, one per write handshake, each carrying its word address and 32-bit data.
- R9: The line index is word-address bits [5:2]. Addresses that differ only above bit 5 evict each other, and addresses with different index bits do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 16 | Word address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Completion, one cycle after acceptance |
| cpu_rsp_rdata | output | 32 | Load data (zero for stores) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = buffered store, 0 = block read |
| mem_req_addr | output | 16 | Word address (block-aligned for reads) |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | One word of a block read |
| mem_rsp_rdata | input | 32 | Block read word, words 0 to 3 in order |

## Verification
Every hit, whether load or store, is accepted in the same cycle that ready is seen high, and its completion is due exactly one cycle later. The bench therefore drives on the falling edge, reads ready just after it, and samples `cpu_rsp_valid` and the data at the next falling edge. A miss, or a store stalled by a full buffer, is measured as a count of cycles that ready stays low. The checks bound that count, for example holding memory off for six cycles must yield six to eight stall cycles. Store draining is asynchronous to the processor, so memory-side results are checked only after the bench has waited for the expected number of write handshakes.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
// Shared types for the write-through cache.
// Assumes: nothing beyond the 1800-2017 language.
package wtc_pkg;
    // Controller states for the load-miss sequence.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,  // serving hits and posting stores
        ST_DRAIN     = 2'd1,  // waiting for the store buffer to empty
        ST_FILL_REQ  = 2'd2,  // presenting the block read
        ST_FILL_DATA = 2'd3   // collecting block beats
    } wtc_state_e;
endpackage

// File: rtl/wtc_array.sv
`timescale 1ns/1ps
// Tag, valid and data storage for a direct-mapped cache.
// Provides a combinational lookup port, a single-word store port and a fill
// port. Assumes store and fill never target the same word in one cycle.
module wtc_array #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_rdata,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_done
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [LINES-1:0]  valid_vec;
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] word_arr [LINES*WORDS];

    logic [IDX_W-1:0] lk_idx, wr_idx, fill_idx;
    logic [OFF_W-1:0] lk_off, wr_off, fill_off;
    logic [TAG_W-1:0] lk_tag, fill_tag;

    assign lk_off   = lk_addr[OFF_W-1:0];
    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign wr_off   = wr_addr[OFF_W-1:0];
    assign wr_idx   = wr_addr[OFF_W +: IDX_W];
    assign fill_off = fill_addr[OFF_W-1:0];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

    logic unused_wr_tag;
    assign unused_wr_tag = ^wr_addr[ADDR_W-1 -: TAG_W];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic             valid_q;
        logic [TAG_W-1:0] tag_q;

        // Valid bit: cleared by reset, set when a fill completes on this line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q <= 1'b0;
            else if (fill_done && fill_idx == IDX_W'(l))
                valid_q <= 1'b1;
        end

        // Tag: loaded from the fill address when the fill completes.
        always_ff @(posedge clk) begin
            if (fill_done && fill_idx == IDX_W'(l))
                tag_q <= fill_tag;
        end

        assign valid_vec[l] = valid_q;
        assign tag_arr[l]   = tag_q;

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            logic [DATA_W-1:0] word_q;

            // Data word: written by a fill beat or by a store hit.
            always_ff @(posedge clk) begin
                if (fill_en && fill_idx == IDX_W'(l) && fill_off == OFF_W'(w))
                    word_q <= fill_data;
                else if (wr_en && wr_idx == IDX_W'(l) && wr_off == OFF_W'(w))
                    word_q <= wr_data;
            end

            assign word_arr[l*WORDS + w] = word_q;
        end
    end

    // Lookup: hit when the indexed line is valid and its tag matches.
    always_comb begin
        lk_hit   = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
        lk_rdata = word_arr[{lk_idx, lk_off}];
    end

    AST_VALID_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_done |=> $stable(valid_vec)); // R5
    AST_ONE_LINE_PER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> ($countones(valid_vec ^ $past(valid_vec)) <= 1)); // R6
endmodule

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
// First-in first-out store buffer holding word address and data for stores
// bound for memory. Assumes the producer never pushes while full and the
// consumer never pops while empty.
module wtc_wbuf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage written at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[wr_ptr] <= push_addr;
            data_mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head_addr = addr_mem[rd_ptr];
    assign head_data = data_mem[rd_ptr];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)); // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push != pop) |=> !$stable(cnt_q)); // R8
endmodule

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
// Request acceptance and load-miss sequencing. A load miss waits for the
// store buffer to empty, issues one block read and counts WORDS beats.
// Assumes the processor holds its request stable while ready is low.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req_valid,
    input  logic                     cpu_req_write,
    input  logic                     lk_hit,
    input  logic                     wb_empty,
    input  logic                     wb_full,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    output logic                     cpu_req_ready,
    output logic                     accept,
    output logic                     fill_req,
    output logic                     fill_busy,
    output logic                     fill_beat,
    output logic [$clog2(WORDS)-1:0] fill_off,
    output logic                     fill_done
);
    localparam int OFF_W = $clog2(WORDS);

    wtc_state_e       state_q, state_d;
    logic [OFF_W-1:0] beat_q;

    // Next-state selection for the miss sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req_valid && !cpu_req_write && !lk_hit) state_d = ST_DRAIN;
            ST_DRAIN:     if (wb_empty) state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_DATA;
            ST_FILL_DATA: if (fill_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Beat counter for the block response.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_FILL_DATA) beat_q <= '0;
        else if (mem_rsp_valid)                beat_q <= beat_q + 1'b1;
    end

    // Handshake and fill control outputs.
    always_comb begin
        cpu_req_ready = (state_q == ST_IDLE) && (cpu_req_write ? !wb_full : lk_hit);
        accept        = cpu_req_valid && cpu_req_ready;
        fill_req      = (state_q == ST_FILL_REQ);
        fill_busy     = (state_q == ST_FILL_REQ) || (state_q == ST_FILL_DATA);
        fill_beat     = (state_q == ST_FILL_DATA) && mem_rsp_valid;
        fill_off      = beat_q;
        fill_done     = fill_beat && (beat_q == OFF_W'(WORDS - 1));
    end

    AST_FILL_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> wb_empty); // R7
    AST_NO_ACCEPT_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !accept); // R6
endmodule

// File: rtl/wtc_cache.sv
`timescale 1ns/1ps
// Direct-mapped write-through, no-write-allocate data cache with a posted
// store buffer. Stores are accepted while the buffer has space; load misses
// drain the buffer, fetch a whole block and then complete as hits.
// Assumes word addresses and a processor that holds requests while stalled.
module wtc_cache #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int LINES    = 16,
    parameter int WORDS    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    localparam int OFF_W = $clog2(WORDS);

    logic              lk_hit;
    logic [DATA_W-1:0] lk_rdata;
    logic              accept, fill_req, fill_busy, fill_beat, fill_done;
    logic [OFF_W-1:0]  fill_off;
    logic              wb_push, wb_pop, wb_empty, wb_full;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;
    logic [ADDR_W-1:0] fill_addr;

    assign wb_push   = accept && cpu_req_write;
    assign fill_addr = {cpu_req_addr[ADDR_W-1:OFF_W], fill_off};

    wtc_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (cpu_req_addr),
        .lk_hit    (lk_hit),
        .lk_rdata  (lk_rdata),
        .wr_en     (wb_push && lk_hit),
        .wr_addr   (cpu_req_addr),
        .wr_data   (cpu_req_wdata),
        .fill_en   (fill_beat),
        .fill_addr (fill_addr),
        .fill_data (mem_rsp_rdata),
        .fill_done (fill_done)
    );

    wtc_wbuf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_addr (cpu_req_addr),
        .push_data (cpu_req_wdata),
        .pop       (wb_pop),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .empty     (wb_empty),
        .full      (wb_full)
    );

    wtc_ctrl #(
        .WORDS(WORDS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .lk_hit        (lk_hit),
        .wb_empty      (wb_empty),
        .wb_full       (wb_full),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .cpu_req_ready (cpu_req_ready),
        .accept        (accept),
        .fill_req      (fill_req),
        .fill_busy     (fill_busy),
        .fill_beat     (fill_beat),
        .fill_off      (fill_off),
        .fill_done     (fill_done)
    );

    // Memory request mux: block read during a fill, otherwise buffer head.
    always_comb begin
        mem_req_valid = fill_req || (!wb_empty && !fill_busy);
        mem_req_write = !fill_req;
        mem_req_addr  = fill_req ? {cpu_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : wb_head_addr;
        mem_req_wdata = wb_head_data;
        wb_pop        = mem_req_valid && mem_req_write && mem_req_ready;
    end

    // Processor completion one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_rdata <= '0;
        end else begin
            cpu_rsp_valid <= accept;
            cpu_rsp_rdata <= (accept && !cpu_req_write) ? lk_rdata : '0;
        end
    end

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_write && wb_full) |-> !cpu_req_ready); // R3
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> cpu_rsp_valid); // R4
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> wb_empty); // R7
    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0)); // R6
    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && !cpu_req_write && !lk_hit) |-> !cpu_req_ready); // R6
endmodule

// File: tb/wtc_cache_bench.sv
`timescale 1ns/1ps
// Directed bench for the write-through cache with a behavioural memory.
module wtc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    wtc_cache u_wtc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // ---------------- behavioural next-level memory ----------------
    logic [31:0] mem [1024];
    logic        mem_ready_en = 1'b1;
    logic        rd_busy;
    logic [1:0]  rd_wait;
    logic [1:0]  rd_beat;
    logic [15:0] rd_base;
    int          rd_req_cnt;
    logic [15:0] last_rd_addr;
    int          wr_cnt;
    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];

    function automatic logic [31:0] init_val(input int a);
        return 32'hA5000000 ^ (a * 32'h00010003);
    endfunction

    assign mem_req_ready = mem_ready_en && !rd_busy;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            rd_busy    <= 1'b0;
            rd_wait    <= '0;
            rd_beat    <= '0;
            rd_req_cnt <= 0;
            wr_cnt     <= 0;
            last_rd_addr <= '0;
            mem_rsp_rdata <= '0;
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr[9:0]] <= mem_req_wdata;
                    log_addr[wr_cnt[5:0]]  <= mem_req_addr;
                    log_data[wr_cnt[5:0]]  <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_busy      <= 1'b1;
                    rd_base      <= mem_req_addr;
                    rd_wait      <= 2'd2;
                    rd_beat      <= '0;
                    rd_req_cnt   <= rd_req_cnt + 1;
                    last_rd_addr <= mem_req_addr;
                end
            end
            if (rd_busy) begin
                if (rd_wait != 0) rd_wait <= rd_wait - 1'b1;
                else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem[rd_base[9:0] + {8'd0, rd_beat}];
                    rd_beat <= rd_beat + 1'b1;
                    if (rd_beat == 2'd3) rd_busy <= 1'b0;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One processor request, starting and ending at a falling edge.
    task automatic cpu_op(input logic wr, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic rv, output int stall);
        stall = 0;
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready && stall < 1000) begin
            @(negedge clk);
            #1;
            stall++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        rd = cpu_rsp_rdata;
        rv = cpu_rsp_valid;
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 300 && wr_cnt < n; i++) @(negedge clk);
    endtask

    int exp_wr = 0;

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
        chk("R1", "cpu_rsp_valid after reset", {31'd0, cpu_rsp_valid}, 32'd0);
    endtask

    task automatic t_cold_read();
        logic [31:0] rd; logic rv; int st;
        cpu_op(1'b0, 16'h0013, '0, rd, rv, st);
        chk("R1", "first load stalls", {31'd0, st > 0}, 32'd1);
        chk("R6", "one block read", rd_req_cnt, 1);
        chk("R6", "aligned read address", {16'd0, last_rd_addr}, 32'h10);
        chk("R6", "miss data", rd, init_val('h13));
        chk("R6", "miss completes", {31'd0, rv}, 32'd1);
        chk("R6", "no writeback", wr_cnt, 0);
    endtask

    task automatic t_hits();
        logic [31:0] rd; logic rv; int st;
        for (int i = 0; i < 3; i++) begin
            cpu_op(1'b0, 16'h0010 + 16'(i), '0, rd, rv, st);
            chk("R2", "hit no stall", st, 0);
            chk("R2", "hit data", rd, init_val('h10 + i));
            chk("R2", "hit rsp", {31'd0, rv}, 32'd1);
        end
        chk("R2", "no memory read on hits", rd_req_cnt, 1);
        cpu_op(1'b0, 16'h0014, '0, rd, rv, st);
        chk("R9", "other index misses", rd_req_cnt, 2);
        cpu_op(1'b0, 16'h0010, '0, rd, rv, st);
        chk("R9", "other index keeps line", st, 0);
        chk("R9", "kept line data", rd, init_val('h10));
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; logic rv; int st;
        cpu_op(1'b1, 16'h0012, 32'hDEAD0001, rd, rv, st);
        exp_wr++;
        chk("R4", "store hit no stall", st, 0);
        chk("R4", "store hit rsp", {31'd0, rv}, 32'd1);
        cpu_op(1'b0, 16'h0012, '0, rd, rv, st);
        chk("R4", "updated word hit", st, 0);
        chk("R4", "updated word data", rd, 32'hDEAD0001);
        wait_writes(exp_wr);
        chk("R8", "write count", wr_cnt, exp_wr);
        chk("R8", "logged addr", {16'd0, log_addr[exp_wr-1]}, 32'h12);
        chk("R4", "memory updated", mem[12'h12], 32'hDEAD0001);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; logic rv; int st;
        int rr = rd_req_cnt;
        cpu_op(1'b1, 16'h0051, 32'hBEEF0002, rd, rv, st);
        exp_wr++;
        chk("R5", "store miss no stall", st, 0);
        cpu_op(1'b0, 16'h0011, '0, rd, rv, st);
        chk("R5", "resident line still hits", st, 0);
        chk("R5", "resident data intact", rd, init_val('h11));
        chk("R5", "no fetch for store miss", rd_req_cnt, rr);
        wait_writes(exp_wr);
        chk("R5", "store miss reached memory", mem[12'h51], 32'hBEEF0002);
        cpu_op(1'b0, 16'h0051, '0, rd, rv, st);
        chk("R6", "conflict load data", rd, 32'hBEEF0002);
        chk("R6", "replacement no writeback", wr_cnt, exp_wr);
        cpu_op(1'b0, 16'h0011, '0, rd, rv, st);
        chk("R9", "bit 6 conflict evicts", {31'd0, st > 0}, 32'd1);
    endtask

    task automatic t_full();
        logic [31:0] rd; logic rv; int st;
        int base = exp_wr;
        mem_ready_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cpu_op(1'b1, 16'h0100 + 16'(i), 32'hF0000000 + i, rd, rv, st);
            chk("R3", "store with space", st, 0);
        end
        fork
            cpu_op(1'b1, 16'h0104, 32'hF0000004, rd, rv, st);
            begin
                repeat (6) @(negedge clk);
                mem_ready_en = 1'b1;
            end
        join
        exp_wr += 5;
        chk("R3", "full stall length", {31'd0, st >= 6 && st <= 8}, 32'd1);
        wait_writes(exp_wr);
        for (int i = 0; i < 5; i++) begin
            chk("R8", "fifo addr order", {16'd0, log_addr[base+i]}, 32'h100 + i);
            chk("R8", "fifo data order", log_data[base+i], 32'hF0000000 + i);
        end
    endtask

    task automatic t_drain_first();
        logic [31:0] rd; logic rv; int st;
        mem_ready_en = 1'b0;
        cpu_op(1'b1, 16'h0200, 32'hCAFE0003, rd, rv, st);
        exp_wr++;
        fork
            cpu_op(1'b0, 16'h0200, '0, rd, rv, st);
            begin
                repeat (4) @(negedge clk);
                mem_ready_en = 1'b1;
            end
        join
        chk("R7", "fetched block has pending store", rd, 32'hCAFE0003);
        chk("R7", "store drained", wr_cnt, exp_wr);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_read();
        t_hits();
        t_write_hit();
        t_write_miss();
        t_full();
        t_drain_first();
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule